// File: doc/BRIEF.md
# Configurable Asynchronous Serial Framer

This block frames characters for an asynchronous serial link. On the transmit side, a parallel write places a byte in a single holding register. The framer then shifts the byte out on the line: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one, one and a half or two high stop bits. On the receive side, the incoming line passes through a synchroniser, is sampled near the middle of each bit, and is reassembled into a right-justified character. A one-cycle strobe presents each received character, and further one-cycle strobes report parity, framing and break conditions.

The framing is set at run time through a 7-bit line-control input. The bit rate comes from a 16-bit divisor supplied as a low byte and a high byte. The divisor sets a tick rate, and sixteen ticks make one bit. A break control forces the transmit line low whatever the transmitter is doing. Buffering deeper than one character, interrupt generation and register decoding belong to the surrounding logic.

Top module: `uart_framer`

## Requirements
- R1: `line_ctl[1:0]` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits leave after a low start bit, least significant bit first. Received data is right-justified, and the unused upper bits read as zero.
- R2: `line_ctl[3]` enables the parity bit, which follows the last data bit. `line_ctl[5:4]` selects its value: 00 makes the count of ones odd, 01 makes it even, 10 sends a constant 1 and 11 sends a constant 0.
- R3: With `line_ctl[2]`=0, one stop bit is sent. With `line_ctl[2]`=1, two stop bits are sent, or one and a half when the length is 5. `tx_line_idle` rises once the last stop bit has ended. While `tx_line_idle` is high and no break is forced, `txd` is high.
- R4: One bit lasts 16 × D clock cycles, where D = {`div_hi`,`div_lo`}.
- R5: When `line_ctl[6]` is 1, `txd` is 0 on the following cycle, whatever the transmitter state. Clearing the bit gives the line back to the framer.
- R6: A `tx_write` is accepted only while `tx_hold_empty` is 1. After an accepted write, `tx_hold_empty` is 0 on the next cycle. A write while the holding register is full is dropped, and the held byte is sent unchanged.
- R7: A received frame with correct parity and a high first stop bit gives a one-cycle `rx_valid`, with `rx_data` holding the character and both error strobes low.
- R8: When parity is enabled and the received parity bit does not match the selected mode, `rx_parity_err` pulses together with `rx_valid`.
- R9: When the first stop bit is sampled as 0 and the frame is not a break, `rx_frame_err` pulses together with `rx_valid`.
- R10: When every sampled bit of a frame is 0 (start, data, parity if enabled, and first stop), `rx_break` pulses and `rx_valid` does not. The receiver then waits for the line to go high before it looks for a new start bit.
- R11: After reset, `txd`, `tx_hold_empty` and `tx_line_idle` are 1, and none of the receive strobes is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_ctl | input | 7 | Framing: [1:0] length, [2] stop select, [3] parity enable, [5:4] parity mode, [6] break |
| div_lo | input | 8 | Low byte of the bit-rate divisor |
| div_hi | input | 8 | High byte of the bit-rate divisor |
| tx_data | input | 8 | Character to send |
| tx_write | input | 1 | Write strobe for the holding register |
| tx_hold_empty | output | 1 | Holding register can take a character |
| tx_line_idle | output | 1 | Nothing held and no frame on the line |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Last received character, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_parity_err | output | 1 | One-cycle strobe: parity mismatch |
| rx_frame_err | output | 1 | One-cycle strobe: first stop bit low |
| rx_break | output | 1 | One-cycle strobe: all-zero frame |

## Verification
The transmitter is run in loopback under eight framing settings that together cover every data length, all four parity modes, parity disabled, and each stop-bit choice. Each data pattern is chosen so that the parity bit differs from the one a neighbouring mode would send. This separates odd from even from constant parity, and a truncated character from a full one. The measured frame duration separates one, one and a half and two stop bits, and a run with only the high divisor byte set shows that both halves reach the bit timing. Hand-built receive frames separate a clean frame, a bad parity bit, a low stop bit with non-zero data, and an all-zero break followed by a clean frame that proves the receiver recovers.

// File: rtl/uart_framer_pkg.sv
package uart_framer_pkg;

  // Framing control word, bit 6 down to bit 0.
  typedef struct packed {
    logic       brk;       // [6] force line low
    logic [1:0] par_mode;  // [5:4]
    logic       par_en;    // [3]
    logic       stop_sel;  // [2]
    logic [1:0] len;       // [1:0] data length minus 5
  } line_cfg_t;

  typedef enum logic [2:0] {
    FR_IDLE, FR_START, FR_DATA, FR_PAR, FR_STOP, FR_HOLD
  } fr_state_t;

  localparam logic [1:0] PAR_ODD   = 2'd0;
  localparam logic [1:0] PAR_EVEN  = 2'd1;
  localparam logic [1:0] PAR_MARK  = 2'd2;
  localparam logic [1:0] PAR_SPACE = 2'd3;

  // Clear the bits above the selected character length.
  function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] len);
    logic [7:0] m;
    m = 8'hFF >> (4'd3 - {2'b00, len});
    return d & m;
  endfunction

  // Parity bit for an already masked character.
  function automatic logic parity_of(input logic [1:0] mode, input logic [7:0] d);
    logic p;
    case (mode)
      PAR_ODD:  p = ~^d;
      PAR_EVEN: p = ^d;
      PAR_MARK: p = 1'b1;
      default:  p = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  // A divisor of 0 or 1 ticks every cycle.
  assign wrap = (div <= DIV_W'(1)) || (cnt >= div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      cnt  <= wrap ? '0 : cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_framer_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  line_cfg_t cfg,
  input  logic [7:0] wr_data,
  input  logic      wr_en,
  output logic      txd,
  output logic      hold_empty,
  output logic      line_idle
);
  localparam int CW = $clog2(2 * OSR);
  localparam logic [CW-1:0] T_BIT    = CW'(OSR - 1);
  localparam logic [CW-1:0] T_STOP15 = CW'(OSR + OSR / 2 - 1);
  localparam logic [CW-1:0] T_STOP2  = CW'(2 * OSR - 1);

  fr_state_t  st;
  logic [7:0] hold, shreg;
  logic       hold_full;
  logic [2:0] bitn, last_bit;
  logic [CW-1:0] tcnt, stop_end;
  logic       par_en_q, par_q;
  logic       line_bit;
  logic       bit_done;

  assign bit_done   = tick && (tcnt == T_BIT);
  assign hold_empty = ~hold_full;
  assign line_idle  = ~hold_full && (st == FR_IDLE);

  always_comb begin
    case (st)
      FR_START: line_bit = 1'b0;
      FR_DATA:  line_bit = shreg[0];
      FR_PAR:   line_bit = par_q;
      default:  line_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= FR_IDLE;
      hold      <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
      bitn      <= '0;
      last_bit  <= '0;
      tcnt      <= '0;
      stop_end  <= T_BIT;
      par_en_q  <= 1'b0;
      par_q     <= 1'b0;
      txd       <= 1'b1;
    end else begin
      txd <= line_bit & ~cfg.brk;
      if (wr_en && !hold_full) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
      if (tick) tcnt <= tcnt + CW'(1);
      case (st)
        FR_IDLE: begin
          if (hold_full) begin
            shreg     <= keep_bits(hold, cfg.len);
            last_bit  <= 3'(3'd4 + {1'b0, cfg.len});
            par_en_q  <= cfg.par_en;
            par_q     <= parity_of(cfg.par_mode, keep_bits(hold, cfg.len));
            stop_end  <= !cfg.stop_sel ? T_BIT :
                         (cfg.len == 2'd0) ? T_STOP15 : T_STOP2;
            hold_full <= 1'b0;
            tcnt      <= '0;
            st        <= FR_START;
          end
        end
        FR_START: begin
          if (bit_done) begin
            tcnt <= '0;
            bitn <= '0;
            st   <= FR_DATA;
          end
        end
        FR_DATA: begin
          if (bit_done) begin
            tcnt  <= '0;
            shreg <= shreg >> 1;
            if (bitn == last_bit) st <= par_en_q ? FR_PAR : FR_STOP;
            else                  bitn <= bitn + 3'd1;
          end
        end
        FR_PAR: begin
          if (bit_done) begin
            tcnt <= '0;
            st   <= FR_STOP;
          end
        end
        FR_STOP: begin
          if (tick && tcnt == stop_end) begin
            tcnt <= '0;
            st   <= FR_IDLE;
          end
        end
        default: st <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_framer_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] len,
  input  logic       par_en,
  input  logic [1:0] par_mode,
  input  logic       rxd,
  output logic [7:0] rdata,
  output logic       rvalid,
  output logic       perr,
  output logic       ferr,
  output logic       brk
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] T_BIT = CW'(OSR - 1);
  localparam logic [CW-1:0] T_MID = CW'(OSR / 2 - 1);

  logic [1:0] sync;
  fr_state_t  st;
  logic [CW-1:0] tcnt;
  logic [2:0] bitn, last_bit;
  logic [7:0] shreg, data_now;
  logic       all_zero, par_rx, par_en_q;
  logic [1:0] mode_q;
  logic       bit_in, sample;

  assign bit_in   = sync[1];
  assign sample   = tick && (tcnt == T_BIT);
  assign data_now = shreg >> (3'd7 - last_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync     <= 2'b11;
      st       <= FR_IDLE;
      tcnt     <= '0;
      bitn     <= '0;
      last_bit <= 3'd7;
      shreg    <= '0;
      all_zero <= 1'b0;
      par_rx   <= 1'b0;
      par_en_q <= 1'b0;
      mode_q   <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
      perr     <= 1'b0;
      ferr     <= 1'b0;
      brk      <= 1'b0;
    end else begin
      sync   <= {sync[0], rxd};
      rvalid <= 1'b0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
      brk    <= 1'b0;
      if (tick) tcnt <= tcnt + CW'(1);
      case (st)
        FR_IDLE: begin
          if (tick && !bit_in) begin
            tcnt     <= '0;
            last_bit <= 3'(3'd4 + {1'b0, len});
            par_en_q <= par_en;
            mode_q   <= par_mode;
            st       <= FR_START;
          end
        end
        FR_START: begin
          if (tick && tcnt == T_MID) begin
            if (bit_in) st <= FR_IDLE;
            else begin
              tcnt     <= '0;
              bitn     <= '0;
              all_zero <= 1'b1;
              st       <= FR_DATA;
            end
          end
        end
        FR_DATA: begin
          if (sample) begin
            tcnt  <= '0;
            shreg <= {bit_in, shreg[7:1]};
            if (bit_in) all_zero <= 1'b0;
            if (bitn == last_bit) st <= par_en_q ? FR_PAR : FR_STOP;
            else                  bitn <= bitn + 3'd1;
          end
        end
        FR_PAR: begin
          if (sample) begin
            tcnt   <= '0;
            par_rx <= bit_in;
            if (bit_in) all_zero <= 1'b0;
            st     <= FR_STOP;
          end
        end
        FR_STOP: begin
          if (sample) begin
            tcnt <= '0;
            if (all_zero && !bit_in) begin
              brk <= 1'b1;
              st  <= FR_HOLD;
            end else begin
              rvalid <= 1'b1;
              rdata  <= data_now;
              perr   <= par_en_q && (par_rx != parity_of(mode_q, data_now));
              ferr   <= !bit_in;
              st     <= FR_IDLE;
            end
          end
        end
        FR_HOLD: begin
          if (bit_in) st <= FR_IDLE;
        end
        default: st <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_framer.sv
module uart_framer
  import uart_framer_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        line_ctl,
  input  logic [HALF_W-1:0] div_lo,
  input  logic [HALF_W-1:0] div_hi,
  input  logic [7:0]        tx_data,
  input  logic              tx_write,
  output logic              tx_hold_empty,
  output logic              tx_line_idle,
  output logic              txd,
  input  logic              rxd,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  output logic              rx_parity_err,
  output logic              rx_frame_err,
  output logic              rx_break
);
  localparam int DIV_W = 2 * HALF_W;

  line_cfg_t        cfg;
  logic [DIV_W-1:0] div_full;
  logic             tick;

  assign cfg      = line_cfg_t'(line_ctl);
  assign div_full = {div_hi, div_lo};

  uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .div(div_full), .tick(tick)
  );

  uart_tx_frame #(.OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .cfg(cfg),
    .wr_data(tx_data), .wr_en(tx_write),
    .txd(txd), .hold_empty(tx_hold_empty), .line_idle(tx_line_idle)
  );

  uart_rx_frame #(.OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick),
    .len(cfg.len), .par_en(cfg.par_en), .par_mode(cfg.par_mode),
    .rxd(rxd), .rdata(rx_data), .rvalid(rx_valid),
    .perr(rx_parity_err), .ferr(rx_frame_err), .brk(rx_break)
  );
endmodule

// File: rtl/uart_framer_chk.sv
module uart_framer_chk (
  input logic       clk,
  input logic       rst,
  input logic [6:0] line_ctl,
  input logic       tx_write,
  input logic       tx_hold_empty,
  input logic       tx_line_idle,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_parity_err,
  input logic       rx_frame_err,
  input logic       rx_break
);
  // R5: forced break reaches the line one cycle later
  a_r5_break_low: assert property (@(posedge clk) disable iff (rst)
    line_ctl[6] |=> !txd);

  // R6: an accepted write fills the holding register
  a_r6_hold_fill: assert property (@(posedge clk) disable iff (rst)
    (tx_write && tx_hold_empty) |=> !tx_hold_empty);

  // R3: idle transmitter keeps the line high
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    (tx_line_idle && !line_ctl[6]) |=> txd);

  // R7: character strobe lasts one cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8: parity strobe only with a character
  a_r8_perr_with_valid: assert property (@(posedge clk) disable iff (rst)
    rx_parity_err |-> rx_valid);

  // R9: framing strobe only with a character
  a_r9_ferr_with_valid: assert property (@(posedge clk) disable iff (rst)
    rx_frame_err |-> rx_valid);

  // R10: a break never delivers a character
  a_r10_break_excl: assert property (@(posedge clk) disable iff (rst)
    rx_break |-> !rx_valid);
endmodule

bind uart_framer uart_framer_chk u_chk (
  .clk(clk), .rst(rst), .line_ctl(line_ctl), .tx_write(tx_write),
  .tx_hold_empty(tx_hold_empty), .tx_line_idle(tx_line_idle), .txd(txd),
  .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
  .rx_frame_err(rx_frame_err), .rx_break(rx_break)
);

// File: tb/tb_uart_framer.sv
module tb_uart_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] lcr = 7'h03;
  logic [7:0] dlo = 8'd2;
  logic [7:0] dhi = 8'd0;
  logic [7:0] tx_data = '0;
  logic       tx_write = 1'b0;
  logic       tx_hold_empty, tx_line_idle, txd;
  logic       rxd, rxd_drv = 1'b1, loop_en = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_parity_err, rx_frame_err, rx_break;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rx_cnt = 0;
  int brk_cnt = 0;
  logic [7:0] rx_last = '0;
  logic       rx_pe = 1'b0, rx_fe = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  assign rxd = loop_en ? txd : rxd_drv;

  uart_framer dut (
    .clk(clk), .rst(rst), .line_ctl(lcr), .div_lo(dlo), .div_hi(dhi),
    .tx_data(tx_data), .tx_write(tx_write), .tx_hold_empty(tx_hold_empty),
    .tx_line_idle(tx_line_idle), .txd(txd), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .rx_break(rx_break)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        rx_cnt  <= rx_cnt + 1;
        rx_last <= rx_data;
        rx_pe   <= rx_parity_err;
        rx_fe   <= rx_frame_err;
      end
      if (rx_break) brk_cnt <= brk_cnt + 1;
    end
  end

  typedef struct packed {
    logic [6:0] lcr;
    logic [7:0] d;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{7'h03, 8'hA5},   // 8 bits, no parity, 1 stop
    '{7'h1B, 8'h37},   // 8 bits, even
    '{7'h0A, 8'hFF},   // 7 bits, odd
    '{7'h28, 8'h1A},   // 5 bits, constant 1
    '{7'h3D, 8'hC3},   // 6 bits, constant 0, 2 stop
    '{7'h04, 8'h15},   // 5 bits, 1.5 stop
    '{7'h0F, 8'h00},   // 8 bits, odd, 2 stop
    '{7'h19, 8'h2A}    // 6 bits, even
  };

  function automatic int nbits_of(input logic [6:0] l);
    return 5 + int'(l[1:0]);
  endfunction

  function automatic logic [7:0] mask_of(input logic [6:0] l, input logic [7:0] d);
    logic [7:0] r;
    r = d;
    for (int i = nbits_of(l); i < 8; i++) r[i] = 1'b0;
    return r;
  endfunction

  function automatic logic par_of(input logic [6:0] l, input logic [7:0] d);
    int ones;
    ones = $countones(mask_of(l, d));
    case (l[5:4])
      2'd0:    return (ones % 2 == 0);
      2'd1:    return (ones % 2 == 1);
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int stop_ticks(input logic [6:0] l);
    if (!l[2]) return 16;
    return (l[1:0] == 2'd0) ? 24 : 32;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    tx_data  = d;
    tx_write = 1'b1;
    @(negedge clk);
    tx_write = 1'b0;
  endtask

  // Decode one frame from txd by sampling at bit centres.
  task automatic grab(input int n, input bit pe, input int bitc,
                      output logic [7:0] d, output logic p, output int t0);
    d = '0;
    p = 1'b0;
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (bitc / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      repeat (bitc) @(negedge clk);
      d[i] = txd;
    end
    if (pe) begin
      repeat (bitc) @(negedge clk);
      p = txd;
    end
    while (txd !== 1'b1) @(negedge clk);
  endtask

  task automatic run_vec(input logic [6:0] l, input logic [7:0] d,
                         input logic [7:0] lo, input logic [7:0] hi);
    int div, bitc, n, t0, len, expl, snap;
    logic [7:0] got;
    logic gp;
    div  = int'({hi, lo});
    bitc = 16 * div;
    n    = nbits_of(l);
    lcr = l; dlo = lo; dhi = hi; loop_en = 1'b1;
    repeat (4) @(negedge clk);
    snap = rx_cnt;
    wr(d);
    grab(n, l[3], bitc, got, gp, t0);
    chk(got == mask_of(l, d), "R1", "tx data bits", int'(got), int'(mask_of(l, d)));
    if (l[3]) chk(gp == par_of(l, d), "R2", "tx parity bit", int'(gp), int'(par_of(l, d)));
    while (!tx_line_idle) @(negedge clk);
    len  = cyc - t0;
    expl = ((1 + n + int'(l[3])) * 16 + stop_ticks(l)) * div;
    chk((len >= expl - div - 3) && (len <= expl + div + 3), "R3 R4",
        "frame length", len, expl);
    repeat (bitc) @(negedge clk);
    chk(rx_cnt == snap + 1, "R7", "rx character count", rx_cnt - snap, 1);
    chk(rx_last == mask_of(l, d), "R7", "rx data", int'(rx_last), int'(mask_of(l, d)));
    chk(!rx_pe && !rx_fe, "R7", "rx error strobes", int'({rx_pe, rx_fe}), 0);
  endtask

  task automatic drive_rx(input logic [15:0] bits, input int n, input int bitc);
    for (int i = 0; i < n; i++) begin
      rxd_drv = bits[i];
      repeat (bitc) @(negedge clk);
    end
    rxd_drv = 1'b1;
    repeat (3 * bitc) @(negedge clk);
  endtask

  task automatic run_all();
    int snap, bsnap, t0;
    logic [7:0] got;
    logic gp;
    bit stayed;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(txd == 1'b1, "R11", "txd after reset", int'(txd), 1);
    chk(tx_hold_empty && tx_line_idle, "R11", "tx flags after reset",
        int'({tx_hold_empty, tx_line_idle}), 3);
    chk(!rx_valid && !rx_break, "R11", "rx strobes after reset",
        int'({rx_valid, rx_break}), 0);

    for (int v = 0; v < NV; v++) run_vec(VEC[v].lcr, VEC[v].d, 8'd2, 8'd0);

    // R4: divisor taken from the high byte alone (256)
    run_vec(7'h00, 8'h0B, 8'h00, 8'h01);
    dlo = 8'd2; dhi = 8'd0;

    // R5: break forcing
    loop_en = 1'b0; rxd_drv = 1'b1; lcr = 7'h43;
    repeat (2) @(negedge clk);
    chk(txd == 1'b0, "R5", "txd under break", int'(txd), 0);
    lcr = 7'h03;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R5", "txd after break release", int'(txd), 1);

    // R6: holding register, a write while full is dropped
    wr(8'h6E);
    chk(tx_hold_empty == 1'b0, "R6", "hold full after write", int'(tx_hold_empty), 0);
    @(negedge clk);
    wr(8'h91);
    wr(8'hFF);
    chk(tx_hold_empty == 1'b0, "R6", "hold still full", int'(tx_hold_empty), 0);
    grab(8, 1'b0, 32, got, gp, t0);
    chk(got == 8'h6E, "R6", "first held byte", int'(got), 8'h6E);
    grab(8, 1'b0, 32, got, gp, t0);
    chk(got == 8'h91, "R6", "second byte kept", int'(got), 8'h91);
    stayed = 1'b1;
    repeat (800) begin
      @(negedge clk);
      if (txd !== 1'b1) stayed = 1'b0;
    end
    chk(stayed && tx_line_idle, "R6", "dropped write never sent", int'(stayed), 1);

    // R9: low stop bit with non-zero data
    snap = rx_cnt;
    drive_rx({6'h3F, 1'b0, 8'h5C, 1'b0}, 10, 32);
    chk(rx_cnt == snap + 1 && rx_last == 8'h5C, "R9", "data with framing error",
        int'(rx_last), 8'h5C);
    chk(rx_fe && !rx_pe, "R9", "framing strobe", int'({rx_fe, rx_pe}), 2);

    // R8: wrong parity bit under even parity
    lcr = 7'h1B;
    repeat (2) @(negedge clk);
    snap = rx_cnt;
    drive_rx({5'h1F, 1'b1, 1'b0, 8'h01, 1'b0}, 11, 32);
    chk(rx_cnt == snap + 1 && rx_last == 8'h01, "R8", "data with parity error",
        int'(rx_last), 8'h01);
    chk(rx_pe && !rx_fe, "R8", "parity strobe", int'({rx_pe, rx_fe}), 2);

    // R10: all-zero frame, then recovery
    lcr = 7'h03;
    repeat (2) @(negedge clk);
    snap = rx_cnt; bsnap = brk_cnt;
    drive_rx(16'h0000, 12, 32);
    chk(brk_cnt == bsnap + 1, "R10", "break strobe count", brk_cnt - bsnap, 1);
    chk(rx_cnt == snap, "R10", "no character on break", rx_cnt - snap, 0);
    drive_rx({6'h3F, 1'b1, 8'h3C, 1'b0}, 10, 32);
    chk(rx_cnt == snap + 1 && rx_last == 8'h3C, "R10", "frame after break",
        int'(rx_last), 8'h3C);
    chk(!rx_pe && !rx_fe, "R7", "clean frame strobes", int'({rx_pe, rx_fe}), 0);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule